// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the two data lines of a low-speed USB port and turns each incoming packet into bytes. A receive buffer is attached to a plain write port. The system clock runs at 12 MHz, so each 1.5 Mbit/s line bit lasts eight clocks. Both lines pass through a two-flop synchronizer. The receiver then waits for the idle (J) state and hunts for a J-to-K drop on D-. It locks its sampling phase to that drop and samples near the middle of every bit. It accepts the packet only when the sync field closes with two K bits.

Once locked, the receiver recovers data bits from level changes and removes the bits the transmitter inserted. It packs the bits into bytes, least significant bit first. Each complete byte is written to consecutive buffer addresses. A single-ended zero (both lines low) ends the packet, and the receiver reports the byte count in a one-cycle pulse. If a packet runs past the buffer size, the receiver gives up and raises an overflow pulse. If a search for sync starts and no edge arrives in time, a miss pulse fires and a free-running miss counter advances. Bus keep-alive strobes show up as such misses. Everything above this level is handled elsewhere: packet identifiers, CRC and transactions.

Top module: `usb_ls_rx`

## Requirements
- R1: Line states are encoded {D+, D-}: J = 01, K = 10, SE0 = 00. Search for sync begins only after the synchronized lines show J, and the lines reach the decoder through two flops each.
- R2: A falling D- edge seen during search starts a sync check. The sample point is BIT_CLKS/2 clocks after that edge. The packet is accepted only if that sample and the one a bit later are both K. Otherwise the receiver goes back to searching, and nothing is written or reported.
- R3: If no falling D- edge arrives within SEARCH_CLKS clocks of entering search, sync_miss pulses for one cycle and miss_count rises by one. The receiver then waits for a fresh falling D- edge before looking for J again. This applies to a search started by reset on an idle bus and to one started by a keep-alive SE0.
- R4: After sync, a sampled D- level equal to the previous bit's level decodes as 1, and a change decodes as 0. Bits fill bytes LSB first. Each complete byte is written with a one-cycle wr_en, with wr_addr counting up from 0 within the packet.
- R5: After six decoded 1s in a row, the next bit is dropped and not counted. The final 1 of the sync field counts toward the six, so a first data byte starting with five 1s is followed by a dropped bit.
- R6: An SE0 sampled at bit positions 1 to 7 of a byte ends the packet. pkt_done pulses for one cycle with pkt_len equal to the number of complete bytes, and any partial byte is discarded.
- R7: An SE0 sampled at bit position 0 of a byte does not end the packet. Its low D- level is decoded like any other bit, so the packet goes on normally.
- R8: When byte DEPTH+1 of a packet completes, overflow pulses for one cycle. That byte is not written, no pkt_done follows, and the next packet is received normally.
- R9: The sampling phase is reloaded at every line transition. Packets whose bits last 7 or 9 clocks are still decoded correctly, as long as no level holds longer than three bits.
- R10: While reset is held, wr_en, pkt_done, overflow, sync_miss and miss_count are all 0.
- R11: After a packet ends, the idle J that follows does not start a search. No miss is counted until the next falling D- edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dp_in | input | 1 | Raw D+ line level |
| dm_in | input | 1 | Raw D- line level |
| wr_en | output | 1 | One-cycle write strobe for a received byte |
| wr_addr | output | AW | Buffer address of the byte, from 0 within a packet |
| wr_data | output | 8 | Received byte |
| pkt_done | output | 1 | One-cycle pulse at end of packet |
| pkt_len | output | LW | Complete bytes in the packet, valid with pkt_done |
| overflow | output | 1 | One-cycle pulse when a packet exceeds DEPTH bytes |
| sync_miss | output | 1 | One-cycle pulse when a search for sync times out |
| miss_count | output | MISS_W | Wrapping count of sync misses |

## Verification
Packets go in with several kinds of content. All-zero bytes change level on every bit. Runs of ones force dropped bits, both at the very start right after sync and across byte boundaries. Mixed bytes check bit order. Bit lengths of 7 and 9 clocks show whether the phase reload keeps sampling centred, which a free-running counter would not. Line patterns that are not full packets separate the end, abort and miss paths from one another: a bare keep-alive SE0, a sync that lacks its closing double K, an SE0 falling mid-byte versus one at a byte's first bit, and a packet one byte longer than the buffer.

// File: rtl/usb_ls_rx_pkg.sv
// Shared types for the low-speed packet receiver.
// Line values are packed {D+, D-}.
package usb_ls_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE_J,
        ST_SEARCH,
        ST_SYNC_CHK,
        ST_DATA,
        ST_ARMED
    } rx_state_e;

    localparam logic [1:0] LN_J   = 2'b01;
    localparam logic [1:0] LN_K   = 2'b10;
    localparam logic [1:0] LN_SE0 = 2'b00;
endpackage

// File: rtl/usb_ls_line_sync.sv
// Multi-stage synchronizer for asynchronous line inputs.
// Assumes each line is a level signal; the reset value is chosen per line
// so the decoder sees a quiet bus after reset.
module usb_ls_line_sync #(
    parameter int               LINES   = 2,
    parameter int               STAGES  = 2,
    parameter logic [LINES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;

        // shift the raw level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], raw[i]};
        end

        assign synced[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/usb_ls_bit_timer.sv
// Bit-phase tracker: a counter reloaded on every line transition, giving one
// sample strobe per bit period near bit centre. Also flags falling D- edges.
// Assumes the line input is already synchronized, packed {D+, D-}.
module usb_ls_bit_timer
    import usb_ls_rx_pkg::*;
#(
    parameter int BIT_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line,
    output logic       samp,
    output logic       dm_fall
);
    localparam int PW   = $clog2(BIT_CLKS);
    localparam int HALF = BIT_CLKS / 2;

    logic [1:0]    line_q;
    logic [PW-1:0] ph;
    logic          trans;

    assign trans = (line != line_q);

    // remember the last line state and advance or reload the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= LN_J;
            ph     <= '0;
        end else begin
            line_q <= line;
            if (trans)                        ph <= PW'(1);
            else if (ph == PW'(BIT_CLKS - 1)) ph <= '0;
            else                              ph <= ph + PW'(1);
        end
    end

    assign samp    = (ph == PW'(HALF));
    assign dm_fall = line_q[0] & ~line[0];
endmodule

// File: rtl/usb_ls_unstuff.sv
// Level-change decoder with inserted-bit removal. A sampled level equal to
// the previous one is a 1; after RUN_MAX ones the next sample is dropped.
// Assumes load is raised on the closing sync bit (level K, one 1 so far).
module usb_ls_unstuff #(
    parameter int RUN_MAX = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  logic dm,
    output logic bit_vld,
    output logic bit_val
);
    localparam int CW = $clog2(RUN_MAX + 1);

    logic          prev;
    logic [CW-1:0] ones;

    assign bit_val = (dm == prev);
    assign bit_vld = (ones != CW'(RUN_MAX));

    // track previous level and the length of the current run of ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b1;
            ones <= '0;
        end else if (load) begin
            prev <= 1'b0;
            ones <= CW'(1);
        end else if (step) begin
            prev <= dm;
            if (!bit_vld)     ones <= '0;
            else if (bit_val) ones <= ones + CW'(1);
            else              ones <= '0;
        end
    end
endmodule

// File: rtl/usb_ls_rx.sv
// Low-speed packet receiver top. Synchronizes the lines, hunts for sync,
// decodes bits and writes bytes to an external buffer. Ends a packet on SE0
// (except at a byte's first bit), aborts on overflow and counts sync misses.
// Assumes a clock of BIT_CLKS cycles per line bit.
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter  int BIT_CLKS    = 8,
    parameter  int DEPTH       = 8,
    parameter  int SEARCH_CLKS = 64,
    parameter  int MISS_W      = 8,
    localparam int AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW          = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_in,
    input  logic              dm_in,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [7:0]        wr_data,
    output logic              pkt_done,
    output logic [LW-1:0]     pkt_len,
    output logic              overflow,
    output logic              sync_miss,
    output logic [MISS_W-1:0] miss_count
);
    localparam int TW     = $clog2(SEARCH_CLKS);
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    logic [1:0]        line_s;
    logic              samp, dm_fall;
    logic              bit_vld, bit_val;
    logic              load_us, step_us;
    logic              is_j, is_k, is_se0;
    rx_state_e         state;
    logic [TW-1:0]     timer;
    logic              chk_second;
    logic [IDX_W-1:0]  bit_idx;
    logic [LW-1:0]     byte_cnt;
    logic [BYTE_W-1:0] shreg, new_byte;

    usb_ls_line_sync #(.LINES(2), .STAGES(2), .RST_VAL(LN_J)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({dp_in, dm_in}), .synced(line_s)
    );

    usb_ls_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .line(line_s), .samp(samp), .dm_fall(dm_fall)
    );

    usb_ls_unstuff #(.RUN_MAX(6)) u_unstuff (
        .clk(clk), .rst_n(rst_n), .load(load_us), .step(step_us),
        .dm(line_s[0]), .bit_vld(bit_vld), .bit_val(bit_val)
    );

    assign is_j     = (line_s == LN_J);
    assign is_k     = (line_s == LN_K);
    assign is_se0   = (line_s == LN_SE0);
    assign load_us  = (state == ST_SYNC_CHK) && samp && is_k && chk_second;
    assign step_us  = (state == ST_DATA) && samp;
    assign new_byte = {bit_val, shreg[BYTE_W-1:1]};

    // receive sequencer: sync hunt, byte assembly, packet end and misses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE_J;
            timer      <= '0;
            chk_second <= 1'b0;
            bit_idx    <= '0;
            byte_cnt   <= '0;
            shreg      <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            pkt_done   <= 1'b0;
            pkt_len    <= '0;
            overflow   <= 1'b0;
            sync_miss  <= 1'b0;
            miss_count <= '0;
        end else begin
            wr_en     <= 1'b0;
            pkt_done  <= 1'b0;
            overflow  <= 1'b0;
            sync_miss <= 1'b0;
            case (state)
                ST_IDLE_J: begin
                    if (is_j) begin
                        state <= ST_SEARCH;
                        timer <= '0;
                    end
                end
                ST_SEARCH: begin
                    if (dm_fall) begin
                        state      <= ST_SYNC_CHK;
                        chk_second <= 1'b0;
                    end else if (timer == TW'(SEARCH_CLKS - 1)) begin
                        sync_miss  <= 1'b1;
                        miss_count <= miss_count + MISS_W'(1);
                        state      <= ST_ARMED;
                    end else begin
                        timer <= timer + TW'(1);
                    end
                end
                ST_SYNC_CHK: begin
                    if (samp) begin
                        if (!is_k) begin
                            state <= ST_SEARCH;
                            timer <= '0;
                        end else if (chk_second) begin
                            state    <= ST_DATA;
                            bit_idx  <= '0;
                            byte_cnt <= '0;
                        end else begin
                            chk_second <= 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (samp) begin
                        if (is_se0 && bit_idx != '0) begin
                            pkt_done <= 1'b1;
                            pkt_len  <= byte_cnt;
                            state    <= ST_ARMED;
                        end else if (bit_vld) begin
                            shreg   <= new_byte;
                            bit_idx <= bit_idx + IDX_W'(1);
                            if (bit_idx == IDX_W'(BYTE_W - 1)) begin
                                if (byte_cnt == LW'(DEPTH)) begin
                                    overflow <= 1'b1;
                                    state    <= ST_ARMED;
                                end else begin
                                    wr_en    <= 1'b1;
                                    wr_addr  <= byte_cnt[AW-1:0];
                                    wr_data  <= new_byte;
                                    byte_cnt <= byte_cnt + LW'(1);
                                end
                            end
                        end
                    end
                end
                ST_ARMED: begin
                    if (dm_fall) state <= ST_IDLE_J;
                end
                default: state <= ST_IDLE_J;
            endcase
        end
    end
endmodule

// File: rtl/usb_ls_rx_chk.sv
// Property checker for the packet receiver, bound to every instance.
// Keeps its own count of writes since the last packet end.
module usb_ls_rx_chk #(
    parameter int DEPTH  = 8,
    parameter int MISS_W = 8,
    parameter int AW     = 3,
    parameter int LW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic              pkt_done,
    input logic [LW-1:0]     pkt_len,
    input logic              overflow,
    input logic              sync_miss,
    input logic [MISS_W-1:0] miss_count
);
    logic [LW-1:0] wcount;

    // count writes, cleared when a packet ends or aborts
    always_ff @(posedge clk) begin
        if (!rst_n)                    wcount <= '0;
        else if (pkt_done || overflow) wcount <= '0;
        else if (wr_en)                wcount <= wcount + LW'(1);
    end

    AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == wcount[AW-1:0]) && (wcount < LW'(DEPTH))); // R4
    AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> pkt_len == wcount); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done); // R6
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (pkt_done || overflow))); // R6
    AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (wcount == LW'(DEPTH)) && !pkt_done); // R8
    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sync_miss |-> miss_count == $past(miss_count) + MISS_W'(1)); // R3
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_miss |-> miss_count == $past(miss_count)); // R3
endmodule

bind usb_ls_rx usb_ls_rx_chk #(
    .DEPTH(DEPTH), .MISS_W(MISS_W), .AW(AW), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .overflow(overflow),
    .sync_miss(sync_miss), .miss_count(miss_count)
);

// File: tb/sim_usb_ls_rx.sv
// Bench for usb_ls_rx: a vector table of packets, then directed cases.
module sim_usb_ls_rx;
    localparam int DEPTH = 8;
    localparam int MAXB  = 12;
    localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;
    // entry: {byte count, clocks per bit, data bytes LSB first}
    localparam logic [47:0] VECS [8] = '{
        48'h01_08_000000A5,
        48'h02_08_0000FFFF,
        48'h03_08_00C33F3F,
        48'h04_08_12345678,
        48'h04_09_55005500,
        48'h04_07_00550055,
        48'h02_08_0000FE7F,
        48'h01_08_00000000
    };

    logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
    logic       wr_en, pkt_done, overflow, sync_miss;
    logic [2:0] wr_addr;
    logic [7:0] wr_data, miss_count;
    logic [3:0] pkt_len;

    int total = 0, bad = 0;
    int wr_total = 0, done_total = 0, ovf_total = 0, miss_pulses = 0;
    int last_len = 0;
    logic [7:0] wlog [256];
    logic [2:0] alog [256];
    logic lvl;
    int ones_tx;
    int w0, d0, o0, m0;
    logic [47:0] ent;
    logic [MAXB*8-1:0] pd;

    always #2 clk = ~clk;

    usb_ls_rx #(.BIT_CLKS(8), .DEPTH(DEPTH), .SEARCH_CLKS(64), .MISS_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .dp_in(dp), .dm_in(dm),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pkt_done(pkt_done), .pkt_len(pkt_len), .overflow(overflow),
        .sync_miss(sync_miss), .miss_count(miss_count)
    );

    // record output events between clock edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                wlog[wr_total % 256] = wr_data;
                alog[wr_total % 256] = wr_addr;
                wr_total++;
            end
            if (pkt_done) begin
                done_total++;
                last_len = int'(pkt_len);
            end
            if (overflow)  ovf_total++;
            if (sync_miss) miss_pulses++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sym(input logic [1:0] s, input int n);
        {dp, dm} = s;
        repeat (n) @(negedge clk);
    endtask

    task automatic put_raw(input logic b, input int bl, input logic drib);
        if (!b) lvl = ~lvl;
        if (drib && !lvl) sym(SE0, bl);
        else              sym(lvl ? J : K, bl);
    endtask

    task automatic put_data(input logic b, input int bl, input logic drib);
        put_raw(b, bl, drib);
        if (b) ones_tx++; else ones_tx = 0;
        if (ones_tx == 6) begin
            put_raw(1'b0, bl, 1'b0);
            ones_tx = 0;
        end
    endtask

    task automatic send(input logic [MAXB*8-1:0] d, input int nbits,
                        input int bl, input int drib);
        lvl = 1'b1;
        for (int i = 0; i < 7; i++) put_raw(1'b0, bl, 1'b0);
        put_raw(1'b1, bl, 1'b0);
        ones_tx = 1;
        for (int i = 0; i < nbits; i++) put_data(d[i], bl, i == drib);
        sym(SE0, 2 * bl);
        sym(J, bl);
        lvl = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic snap();
        w0 = wr_total; d0 = done_total; o0 = ovf_total; m0 = int'(miss_count);
    endtask

    task automatic check_pkt(input string tag, input logic [MAXB*8-1:0] d,
                             input int n);
        chk({tag, " done"}, done_total - d0, 1);
        chk({tag, " len"}, last_len, n);
        chk({tag, " writes"}, wr_total - w0, n);
        chk({tag, " ovf"}, ovf_total - o0, 0);
        for (int i = 0; i < n; i++) begin
            chk({tag, " data"}, wlog[(w0 + i) % 256], d[8*i +: 8]);
            chk({tag, " addr"}, alog[(w0 + i) % 256], i);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (5) @(negedge clk);
        chk("R10 wr_en", wr_en, 0);
        chk("R10 pkt_done", pkt_done, 0);
        chk("R10 overflow", overflow, 0);
        chk("R10 sync_miss", sync_miss, 0);
        chk("R10 miss_count", miss_count, 0);
        rst_n = 1'b1;

        // R1 R3: idle J after reset starts a search that times out once
        repeat (100) @(negedge clk);
        chk("R3 miss after reset", miss_count, 1);
        chk("R1 R3 miss pulses", miss_pulses, 1);

        // table: R2 R4 R5 R6 R9 R11
        for (int v = 0; v < 8; v++) begin
            ent = VECS[v];
            pd  = '0;
            pd[31:0] = ent[31:0];
            snap();
            send(pd, 8 * int'(ent[47:40]), int'(ent[39:32]), -1);
            check_pkt("R4 R5 R6 R9", pd, int'(ent[47:40]));
            chk("R11 no miss after packet", miss_count, m0);
        end

        // R3: keep-alive SE0 then idle counts as a miss
        snap();
        sym(SE0, 16); sym(J, 8);
        repeat (100) @(negedge clk);
        chk("R3 keepalive miss", miss_count, m0 + 1);
        chk("R3 keepalive no done", done_total - d0, 0);

        // R2: sync without the closing double K is rejected
        snap();
        sym(K, 8); sym(J, 8); sym(K, 8); sym(J, 8);
        repeat (100) @(negedge clk);
        chk("R2 false sync no done", done_total - d0, 0);
        chk("R2 false sync no write", wr_total - w0, 0);
        chk("R2 false sync miss", miss_count, m0 + 1);

        // R6: SE0 in the middle of the second byte
        snap();
        pd = '0; pd[15:0] = 16'h3CA5;
        send(pd, 11, 8, -1);
        check_pkt("R6 mid-byte", pd, 1);

        // R7: SE0 replacing a K at bit 0 of byte 1
        snap();
        pd = '0; pd[23:0] = 24'h550100;
        send(pd, 24, 8, 8);
        check_pkt("R7 dribble", pd, 3);

        // R8: one byte beyond the buffer
        snap();
        pd = '0;
        send(pd, 8 * (DEPTH + 1), 8, -1);
        chk("R8 writes", wr_total - w0, DEPTH);
        chk("R8 overflow", ovf_total - o0, 1);
        chk("R8 no done", done_total - d0, 0);
        chk("R8 last addr", alog[(w0 + DEPTH - 1) % 256], DEPTH - 1);

        // R8: next packet received normally
        snap();
        pd = '0; pd[7:0] = 8'h5A;
        send(pd, 8, 8, -1);
        check_pkt("R8 recovery", pd, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule